// File: doc/BRIEF.md
# Half-Duplex SPI Flash Master

This block is a register-mapped SPI master for flash-style command traffic. The host loads a 32-bit command word and up to eight 32-bit data words, then sets a bit count for each of three phases and a clock divide ratio. Writing the start bit runs one transaction. A transaction shifts the command word, then extra transmit bytes taken from the data words, then clocks in a receive stream that overwrites the data words. The host polls a busy flag and then reads the received bytes back.

Chip selects come from their own register and are never driven by the transaction engine. Software can therefore keep one device selected across several transactions, for example a command transaction followed by a long read. Only SPI mode 0 is produced: SCK idles low, MOSI changes while SCK is low, and MISO is sampled as SCK rises.

The phase sequencer has five states. `ST_IDLE` is the rest state. `ST_OPC` shifts the command, `ST_TXD` shifts the extra transmit bytes, `ST_RXD` receives, and `ST_FIN` is a one-cycle wind-down.
- IDLE→OPC, IDLE→TXD, IDLE→RXD and IDLE→FIN are taken on an accepted start. The target is the first phase with a nonzero count.
- OPC→TXD, OPC→RXD and OPC→FIN are taken after the last command bit, again to the next nonempty phase.
- TXD→RXD and TXD→FIN are taken after the last transmit bit.
- RXD→FIN is taken after the last receive bit.
- FIN→IDLE is taken unconditionally.

Top module: `spi_flash_master`

## Requirements
- R1: After reset, busy reads 0, SCK is low and every `cs_n` bit is high. The configuration word (address 10) and the count word (address 11) read 0.
- R2: The SCK period is D+2 system clocks, where D is the 12-bit field in bits 27:16 of the configuration word (address 10). SCK is high for floor((D+2)/2) clocks of each period, and the period is unbroken across phase boundaries.
- R3: Writing a word with bit 8 set to the control word (address 0) starts a transaction. Bit 16 of the same word reads back busy. A start written while busy is ignored, so the transaction's length and SCK count are unchanged.
- R4: The count word (address 11) holds the command-phase bit count in bits 31:24 (at most 32), the receive bit count in bits 23:12 (at most 256) and the extra transmit bit count in bits 11:0 (at most 256). Phases run in the order command, transmit, receive, and a phase with a zero count is skipped.
- R5: The command word (address 1) is shifted out starting with its most significant byte.
- R6: The transmit phase begins at byte 0 of data word 0 (address 2) and walks the data words (addresses 2 to 9) at increasing addresses, with each word sent least significant byte first.
- R7: Received bytes are written into the data words starting at byte 0 of address 2, least significant byte first. Data bytes beyond the received bit count keep their earlier value.
- R8: Bit 3 of the configuration word selects the bit order within each byte: 0 sends the most significant bit first and 1 sends the least significant bit first. Received bits are stored in the same order.
- R9: Setting bit i of the chip-select word (address 12) drives `cs_n[i]` low, and clearing it drives `cs_n[i]` high. `cs_n` changes only on a write to that word, never because of a transaction.
- R10: SCK stays low whenever busy is clear, and MOSI holds steady while SCK is high.
- R11: MOSI is 0 throughout the receive phase.
- R12: With N total bits, busy reads 1 from the clock after the start write until it clears N·(D+2)+1 clocks later. That is one clock after the last SCK falling edge. With all counts zero, busy clears one clock after the start and SCK never toggles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for `addr` (combinational) |
| sck | output | 1 | SPI clock, mode 0 |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |
| cs_n | output | NCS | Active-low chip selects |

## Verification
The checker assumes the host keeps away from the command, data, configuration and count words while busy is set. It also assumes the counts stay within their stated maxima, since the shifter reads and writes the byte buffer live. The bench follows this by polling busy after every start before touching any register. Its only write during a transaction is a second start, which is exactly the case R3 calls for. The bench's device model changes MISO only on SCK falling edges, and so matches the rising-edge sampling the receive path relies on.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;
    localparam int ADDR_W     = 4;
    localparam int DATA_WORDS = 8;
    localparam int OPC_BYTES  = 4;
    localparam int BUF_BYTES  = OPC_BYTES + 4 * DATA_WORDS;
    localparam int BIDX_W     = $clog2(BUF_BYTES);
    localparam int CNT_W      = 12;

    localparam logic [ADDR_W-1:0] A_XFER   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_OPCODE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_DATA0  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(2 + DATA_WORDS);
    localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(3 + DATA_WORDS);
    localparam logic [ADDR_W-1:0] A_CSEL   = ADDR_W'(4 + DATA_WORDS);

    localparam int START_BIT = 8;
    localparam int BUSY_BIT  = 16;
    localparam int LSBF_BIT  = 3;
    localparam int DIV_LSB   = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_TXD,
        ST_RXD,
        ST_FIN
    } seq_state_t;
endpackage

// File: rtl/spi_fm_regs.sv
module spi_fm_regs
    import spi_fm_pkg::*;
#(
    parameter int NCS   = 2,
    parameter int DIV_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              busy,
    output logic              start,
    output logic [DIV_W-1:0]  div,
    output logic              lsb_first,
    output logic [7:0]        op_bits,
    output logic [CNT_W-1:0]  tx_bits,
    output logic [CNT_W-1:0]  rx_bits,
    output logic [NCS-1:0]    csel,
    input  logic [BIDX_W-1:0] tx_idx,
    output logic [7:0]        tx_byte,
    input  logic              rx_we,
    input  logic [BIDX_W-1:0] rx_idx,
    input  logic [2:0]        rx_pos,
    input  logic              rx_bit
);
    logic [7:0]       buf_q [BUF_BYTES];
    logic [DIV_W-1:0] div_q;
    logic             lsb_q;
    logic [7:0]       op_q;
    logic [CNT_W-1:0] tx_q;
    logic [CNT_W-1:0] rx_q;
    logic [NCS-1:0]   csel_q;

    assign start = wr_en && (addr == A_XFER) && wdata[START_BIT] && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BUF_BYTES; i++) buf_q[i] <= '0;
            div_q  <= '0;
            lsb_q  <= 1'b0;
            op_q   <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
            csel_q <= '0;
        end else begin
            if (wr_en) begin
                if (addr == A_OPCODE) begin
                    for (int b = 0; b < OPC_BYTES; b++)
                        buf_q[b] <= wdata[8*(OPC_BYTES-1-b) +: 8];
                end
                for (int w = 0; w < DATA_WORDS; w++) begin
                    if (addr == ADDR_W'(int'(A_DATA0) + w)) begin
                        for (int b = 0; b < 4; b++)
                            buf_q[OPC_BYTES + 4*w + b] <= wdata[8*b +: 8];
                    end
                end
                if (addr == A_CFG) begin
                    div_q <= wdata[DIV_LSB +: DIV_W];
                    lsb_q <= wdata[LSBF_BIT];
                end
                if (addr == A_COUNT) begin
                    op_q <= wdata[31:24];
                    rx_q <= wdata[23:12];
                    tx_q <= wdata[11:0];
                end
                if (addr == A_CSEL) csel_q <= wdata[NCS-1:0];
            end
            if (rx_we && (int'(rx_idx) < BUF_BYTES))
                buf_q[rx_idx][rx_pos] <= rx_bit;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_XFER)   rdata[BUSY_BIT] = busy;
        if (addr == A_OPCODE) begin
            for (int b = 0; b < OPC_BYTES; b++)
                rdata[8*(OPC_BYTES-1-b) +: 8] = buf_q[b];
        end
        for (int w = 0; w < DATA_WORDS; w++) begin
            if (addr == ADDR_W'(int'(A_DATA0) + w)) begin
                for (int b = 0; b < 4; b++)
                    rdata[8*b +: 8] = buf_q[OPC_BYTES + 4*w + b];
            end
        end
        if (addr == A_CFG) begin
            rdata[DIV_LSB +: DIV_W] = div_q;
            rdata[LSBF_BIT]         = lsb_q;
        end
        if (addr == A_COUNT) rdata = {op_q, rx_q, tx_q};
        if (addr == A_CSEL)  rdata[NCS-1:0] = csel_q;
    end

    assign tx_byte   = (int'(tx_idx) < BUF_BYTES) ? buf_q[tx_idx] : 8'h00;
    assign div       = div_q;
    assign lsb_first = lsb_q;
    assign op_bits   = op_q;
    assign tx_bits   = tx_q;
    assign rx_bits   = rx_q;
    assign csel      = csel_q;
endmodule

// File: rtl/spi_fm_bitclk.sv
module spi_fm_bitclk #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             sck_hi,
    output logic             rise_now,
    output logic             bit_last
);
    localparam int R_W = DIV_W + 1;

    logic [R_W-1:0] ratio;
    logic [R_W-1:0] low_len;
    logic [R_W-1:0] cnt_q;

    assign ratio   = R_W'(div) + R_W'(2);
    assign low_len = ratio - (ratio >> 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        cnt_q <= '0;
        else if (!run)                     cnt_q <= '0;
        else if (cnt_q == ratio - 1'b1)    cnt_q <= '0;
        else                               cnt_q <= cnt_q + 1'b1;
    end

    assign sck_hi   = run && (cnt_q >= low_len);
    assign rise_now = run && (cnt_q == low_len - 1'b1);
    assign bit_last = run && (cnt_q == ratio - 1'b1);
endmodule

// File: rtl/spi_fm_seq.sv
module spi_fm_seq
    import spi_fm_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        op_bits,
    input  logic [CNT_W-1:0]  tx_bits,
    input  logic [CNT_W-1:0]  rx_bits,
    input  logic              lsb_first,
    input  logic [DIV_W-1:0]  div,
    input  logic [7:0]        tx_byte,
    input  logic              miso,
    output logic [BIDX_W-1:0] byte_idx,
    output logic              rx_we,
    output logic [2:0]        bit_pos,
    output logic              rx_bit,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    output seq_state_t        state
);
    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] bitcnt_q;
    logic [CNT_W-1:0] cur_len;
    logic             run, sck_hi, rise_now, bit_last, phase_done;
    seq_state_t       after_opc, after_txd, after_rxd;

    spi_fm_bitclk #(.DIV_W(DIV_W)) u_bitclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .div      (div),
        .sck_hi   (sck_hi),
        .rise_now (rise_now),
        .bit_last (bit_last)
    );

    // next nonempty phase after each point of the fixed order
    assign after_rxd = (rx_bits != '0) ? ST_RXD : ST_FIN;
    assign after_txd = (tx_bits != '0) ? ST_TXD : after_rxd;
    assign after_opc = (op_bits != '0) ? ST_OPC : after_txd;

    assign phase_done = bit_last && (bitcnt_q == cur_len - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)      state_d = after_opc;
            ST_OPC:  if (phase_done) state_d = after_txd;
            ST_TXD:  if (phase_done) state_d = after_rxd;
            ST_RXD:  if (phase_done) state_d = ST_FIN;
            ST_FIN:                  state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  bitcnt_q <= '0;
        else if (state_d != state_q) bitcnt_q <= '0;
        else if (bit_last)           bitcnt_q <= bitcnt_q + 1'b1;
    end

    always_comb begin
        run      = 1'b0;
        cur_len  = '0;
        byte_idx = BIDX_W'(bitcnt_q >> 3) + BIDX_W'(OPC_BYTES);
        mosi     = 1'b0;
        rx_we    = 1'b0;
        bit_pos  = lsb_first ? bitcnt_q[2:0] : (3'd7 - bitcnt_q[2:0]);
        unique case (state_q)
            ST_IDLE: ;
            ST_OPC: begin
                run      = 1'b1;
                cur_len  = CNT_W'(op_bits);
                byte_idx = BIDX_W'(bitcnt_q >> 3);
                mosi     = tx_byte[bit_pos];
            end
            ST_TXD: begin
                run     = 1'b1;
                cur_len = tx_bits;
                mosi    = tx_byte[bit_pos];
            end
            ST_RXD: begin
                run     = 1'b1;
                cur_len = rx_bits;
                rx_we   = rise_now;
            end
            ST_FIN: ;
            default: ;
        endcase
    end

    assign rx_bit = miso;
    assign busy   = (state_q != ST_IDLE);
    assign sck    = sck_hi;
    assign state  = state_q;
endmodule

// File: rtl/spi_flash_master.sv
module spi_flash_master
    import spi_fm_pkg::*;
#(
    parameter int NCS   = 2,
    parameter int DIV_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [NCS-1:0]    cs_n
);
    logic              busy_w, start_w, lsb_w, rx_we_w, rx_bit_w;
    logic [DIV_W-1:0]  div_w;
    logic [7:0]        op_w, tx_byte_w;
    logic [CNT_W-1:0]  txb_w, rxb_w;
    logic [NCS-1:0]    csel_w;
    logic [BIDX_W-1:0] idx_w;
    logic [2:0]        pos_w;
    seq_state_t        seq_state_w;

    spi_fm_regs #(.NCS(NCS), .DIV_W(DIV_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .busy      (busy_w),
        .start     (start_w),
        .div       (div_w),
        .lsb_first (lsb_w),
        .op_bits   (op_w),
        .tx_bits   (txb_w),
        .rx_bits   (rxb_w),
        .csel      (csel_w),
        .tx_idx    (idx_w),
        .tx_byte   (tx_byte_w),
        .rx_we     (rx_we_w),
        .rx_idx    (idx_w),
        .rx_pos    (pos_w),
        .rx_bit    (rx_bit_w)
    );

    spi_fm_seq #(.DIV_W(DIV_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_w),
        .op_bits   (op_w),
        .tx_bits   (txb_w),
        .rx_bits   (rxb_w),
        .lsb_first (lsb_w),
        .div       (div_w),
        .tx_byte   (tx_byte_w),
        .miso      (miso),
        .byte_idx  (idx_w),
        .rx_we     (rx_we_w),
        .bit_pos   (pos_w),
        .rx_bit    (rx_bit_w),
        .busy      (busy_w),
        .sck       (sck),
        .mosi      (mosi),
        .state     (seq_state_w)
    );

    assign cs_n = ~csel_w;
endmodule

// File: rtl/spi_flash_master_chk.sv
module spi_flash_master_chk
    import spi_fm_pkg::*;
#(
    parameter int NCS = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start_req,
    input logic           cs_wr,
    input logic [NCS-1:0] cs_wdata,
    input logic           busy,
    input logic           sck,
    input logic           mosi,
    input logic [NCS-1:0] cs_n,
    input seq_state_t     state
);
    a_r10_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);

    a_r10_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));

    a_r11_rx_mosi_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RXD) |-> !mosi);

    a_r9_cs_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        cs_wr |=> (cs_n == ~$past(cs_wdata)));

    a_r9_cs_held: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_wr |=> $stable(cs_n));

    a_r3_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_req));

    a_r4_rx_is_last: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_RXD && state != ST_RXD) |-> (state == ST_FIN));

    a_r12_fin_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIN) |=> (state == ST_IDLE && !busy));

    a_r12_busy_clears_from_fin: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(state) == ST_FIN));
endmodule

bind spi_flash_master spi_flash_master_chk #(.NCS(NCS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (wr_en && (addr == spi_fm_pkg::A_XFER) && wdata[spi_fm_pkg::START_BIT]),
    .cs_wr     (wr_en && (addr == spi_fm_pkg::A_CSEL)),
    .cs_wdata  (wdata[NCS-1:0]),
    .busy      (busy_w),
    .sck       (sck),
    .mosi      (mosi),
    .cs_n      (cs_n),
    .state     (seq_state_w)
);

// File: tb/tb_spi_flash_master.sv
module tb_spi_flash_master;
    import spi_fm_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic              miso = 1'b0;
    wire  [31:0]       rdata;
    wire               sck, mosi;
    wire  [1:0]        cs_n;

    spi_flash_master #(.NCS(2), .DIV_W(12)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // device model: records MOSI on rising SCK, updates MISO on falling SCK
    int ncap = 0;
    int seed_g = 0;
    bit cap [0:1023];

    function automatic bit pat(int n, int s);
        return bit'((((n * 5 + s) >> 1) ^ (n >> 2)) & 1);
    endfunction

    function automatic logic [31:0] dword(int w, int s);
        return (32'h9E3779B9 * 32'(w + 1)) ^ (32'h01010101 * 32'(s));
    endfunction

    always @(posedge sck) begin
        if (ncap < 1024) cap[ncap] = mosi;
        ncap++;
    end

    always @(negedge sck) miso = pat(ncap, seed_g);

    // SCK timing monitor, sampled on falling system clock
    int tcyc = 0;
    bit prev_sck = 1'b0;
    int last_rise = -1;
    int hi_len = 0;
    int bad_per = 0;
    int bad_hi = 0;
    int exp_r = 2;

    always @(negedge clk) begin
        tcyc++;
        if (sck && !prev_sck) begin
            if (last_rise >= 0 && (tcyc - last_rise) != exp_r) bad_per++;
            last_rise = tcyc;
            hi_len = 1;
        end else if (sck) begin
            hi_len++;
        end
        if (!sck && prev_sck && hi_len != exp_r / 2) bad_hi++;
        prev_sck = sck;
    end

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic run_xfer(int dv, bit lsb, int opb, int txb, int rxb,
                            logic [31:0] opc, int s, bit restart, string req);
        logic [7:0]  expb [0:35];
        logic [31:0] dw, rv, ev;
        logic [7:0]  byt;
        int r, n, k, bad, d, j;
        bit eb;
        r = dv + 2;
        n = opb + txb + rxb;
        for (int w = 0; w < DATA_WORDS; w++) begin
            dw = dword(w, s);
            wr(ADDR_W'(int'(A_DATA0) + w), dw);
            for (int b = 0; b < 4; b++) expb[4 + 4*w + b] = dw[8*b +: 8];
        end
        wr(A_OPCODE, opc);
        wr(A_CFG, 32'(dv << 16) | 32'(int'(lsb) << 3));
        wr(A_COUNT, 32'(opb << 24) | 32'(rxb << 12) | 32'(txb));
        ncap = 0;
        seed_g = s;
        miso = pat(0, s);
        exp_r = r;
        last_rise = -1;
        bad_per = 0;
        bad_hi = 0;
        wr(A_XFER, 32'h0000_0100);
        k = 0;
        rd(A_XFER, rv);
        while (rv[16] && k < 100000) begin
            @(negedge clk);
            k++;
            if (restart && k == 3) begin
                wr_en = 1'b1;
                wdata = 32'h0000_0100;
            end else if (restart && k == 4) begin
                wr_en = 1'b0;
            end
            rd(A_XFER, rv);
        end
        wr_en = 1'b0;
        // R12: busy length; R3 when restart is set
        chk(k == n * r + 1, restart ? "R3" : "R12", {req, " busy clocks"}, k, n * r + 1);
        chk(ncap == n, "R4", {req, " SCK rising edges"}, ncap, n);
        bad = 0;
        for (int i = 0; i < n && i < 1024; i++) begin
            if (i < opb) begin
                d = i / 8; j = i % 8;
                byt = opc[8*(3 - d) +: 8];
                eb = byt[lsb ? j : 7 - j];
            end else if (i < opb + txb) begin
                d = (i - opb) / 8; j = (i - opb) % 8;
                byt = expb[4 + d];
                eb = byt[lsb ? j : 7 - j];
            end else begin
                eb = 1'b0; // R11: receive phase sends zeros
            end
            if (cap[i] != eb) bad++;
        end
        chk(bad == 0, lsb ? "R8" : "R5", {req, " MOSI bit mismatches (R6 R11)"}, bad, 0);
        if (n >= 2)
            chk(bad_per == 0 && bad_hi == 0, "R2", {req, " SCK period/high errors"},
                bad_per + bad_hi, 0);
        for (int kk = 0; kk < rxb; kk++) begin
            d = kk / 8; j = kk % 8;
            expb[4 + d][lsb ? j : 7 - j] = pat(opb + txb + kk, s);
        end
        bad = 0;
        for (int w = 0; w < DATA_WORDS; w++) begin
            rd(ADDR_W'(int'(A_DATA0) + w), rv);
            ev = {expb[4 + 4*w + 3], expb[4 + 4*w + 2], expb[4 + 4*w + 1], expb[4 + 4*w]};
            if (rv != ev) bad++;
        end
        chk(bad == 0, "R7", {req, " data words wrong after receive"}, bad, 0);
    endtask

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        // R1: reset state, sampled while still in reset and after release
        chk(sck == 1'b0, "R1", "sck in reset", sck, 0);
        chk(cs_n == 2'b11, "R1", "cs_n in reset", cs_n, 3);
        rst_n = 1'b1;
        @(negedge clk);
        rd(A_XFER, rv);  chk(rv[16] == 1'b0, "R1", "busy after reset", rv[16], 0);
        rd(A_CFG, rv);   chk(rv == 32'h0, "R1", "config after reset", rv, 0);
        rd(A_COUNT, rv); chk(rv == 32'h0, "R1", "count after reset", rv, 0);

        // R9: chip-select register
        wr(A_CSEL, 32'h1); chk(cs_n == 2'b10, "R9", "cs_n for select 1", cs_n, 2);
        wr(A_CSEL, 32'h2); chk(cs_n == 2'b01, "R9", "cs_n for select 2", cs_n, 1);
        wr(A_CSEL, 32'h3); chk(cs_n == 2'b00, "R9", "cs_n for select 3", cs_n, 0);
        wr(A_CSEL, 32'h0); chk(cs_n == 2'b11, "R9", "cs_n for select 0", cs_n, 3);

        // sweep of divider and bit order over one mixed shape
        for (int dv = 0; dv < 4; dv++) begin
            for (int lb = 0; lb < 2; lb++) begin
                run_xfer(dv, bit'(lb), 8, 16, 16, 32'hA5C3_1E77 ^ 32'(dv * 17 + lb), dv * 2 + lb,
                         1'b0, "sweep");
            end
        end

        // R5: full command word then receive
        run_xfer(1, 1'b0, 32, 0, 32, 32'h0B12_3456, 11, 1'b0, "R5 cmd32");
        // R6: transmit phase only, all data words
        run_xfer(0, 1'b0, 0, 256, 0, 32'h0, 12, 1'b0, "R6 tx256");
        // R7: receive only, fills all data words
        run_xfer(0, 1'b1, 0, 0, 256, 32'h0, 13, 1'b0, "R7 rx256");
        // R4: partial byte counts
        run_xfer(2, 1'b0, 24, 8, 12, 32'hDEAD_BEEF, 14, 1'b0, "R4 partial");
        // R2: large divider
        run_xfer(100, 1'b0, 8, 0, 0, 32'h9F00_0000, 15, 1'b0, "R2 slow");
        // R12: empty transaction
        run_xfer(3, 1'b0, 0, 0, 0, 32'h0, 16, 1'b0, "R12 empty");
        // R3: restart while busy is ignored
        run_xfer(2, 1'b0, 32, 32, 16, 32'h1357_9BDF, 17, 1'b1, "R3 restart");

        // R9: chip select held across transactions
        wr(A_CSEL, 32'h1);
        run_xfer(0, 1'b0, 8, 8, 8, 32'h0300_0000, 18, 1'b0, "R9 held");
        chk(cs_n == 2'b10, "R9", "cs_n after transaction", cs_n, 2);
        wr(A_CSEL, 32'h0);
        chk(cs_n == 2'b11, "R9", "cs_n after release", cs_n, 3);
        chk(sck == 1'b0, "R10", "sck idle after traffic", sck, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R12 watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule